// File: doc/BRIEF.md
# Process Input Change Monitor

This block sits beside a cycle-based simulation engine and decides, once per simulation cycle, which of a fixed set of simulation processes actually need to execute. The engine reports each monitored input of each process as an indexed write carrying a process number, a signal slot within that process and the signal's current value. The block keeps the last reported value of every slot. When a report differs from the stored value, it marks the owning process as changed. A trigger strobe closes the simulation cycle. It publishes a run/skip vector with one bit per process and starts a fresh change window.

For each process the block also counts how often it was triggered and how often it was told to run. Both counters saturate at their top value. A read port selects one process and returns its two counts, together with an activity flag. The flag is set when that process's run-to-trigger ratio exceeds a percentage threshold. The comparison uses cross-multiplication, so no divider is needed. The engine can sweep the threshold to decide which processes are worth placing in faster execution resources.

Top module: `pim_monitor`

## Requirements
- R1: After reset every stored value is 0, every counter is 0, `run_vec` is 0 and `rd_active` is 0, and every process is marked changed, so the first trigger sets all 32 bits of `run_vec`.
- R2: A write whose value differs from the stored value of slot (`wr_proc`, `wr_sig`) stores the new value and marks process `wr_proc` changed.
- R3: A write whose value equals the stored value marks nothing, so it leaves that process's next run bit at 0.
- R4: On the edge where `trig` is high, bit p of `run_vec` becomes 1 exactly when process p was marked changed since the previous trigger. All marks then clear, and `run_vec` holds until the next trigger.
- R5: A changing write in the same cycle as `trig` is not part of the run bit of that trigger. It counts toward the following trigger.
- R6: Each trigger adds 1 to the trigger count of every process, and adds 1 to the run count of each process whose new run bit is 1.
- R7: The trigger and run counts stop at 2^CNT_W-1 (1023 by default) and never wrap.
- R8: `rd_active` is 1 exactly when run_count*100 > thresh_pct*trigger_count for the read process. A process with no triggers is therefore never active.
- R9: `rd_trig_cnt`, `rd_run_cnt` and `rd_active` show the counts of process `rd_proc` as they stood on the previous clock edge, with one register stage.
- R10: A write touches only its own process. The marks of all other processes stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Signal value report valid |
| wr_proc | input | 5 | Process number of the report |
| wr_sig | input | 2 | Signal slot within the process |
| wr_value | input | 16 | Current value of the signal |
| trig | input | 1 | End-of-simulation-cycle strobe |
| run_vec | output | 32 | Run (1) / skip (0) per process, from the last trigger |
| thresh_pct | input | 7 | Activity threshold in percent |
| rd_proc | input | 5 | Process selected on the read port |
| rd_trig_cnt | output | 10 | Trigger count of the selected process |
| rd_run_cnt | output | 10 | Run count of the selected process |
| rd_active | output | 1 | Ratio above threshold for the selected process |

## Verification
A write updates the stored value and the change mark on the edge where it is taken. Its effect becomes visible only through `run_vec`, which changes on the edge of the next trigger. The counters step on that same trigger edge. Because the read port adds one register stage, they appear on `rd_*` one edge later. The bench drives inputs on falling edges. It samples `run_vec` at the falling edge right after the trigger edge. It reads counters only after holding `rd_proc` for a full cycle past the last trigger, so every check lands after all registers on the path have updated.

// File: rtl/pim_pkg.sv
package pim_pkg;
    parameter int unsigned NPROC = 32;
    parameter int unsigned NSIG  = 4;
    parameter int unsigned VAL_W = 16;
    parameter int unsigned CNT_W = 10;
    parameter int unsigned PCT_W = 7;
    localparam int unsigned PCT_SCALE = 100;
endpackage

// File: rtl/pim_value_store.sv
module pim_value_store #(
    parameter int unsigned NPROC = 32,
    parameter int unsigned NSIG  = 4,
    parameter int unsigned VAL_W = 16,
    localparam int unsigned PID_W = $clog2(NPROC),
    localparam int unsigned SID_W = (NSIG > 1) ? $clog2(NSIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PID_W-1:0] wr_proc,
    input  logic [SID_W-1:0] wr_sig,
    input  logic [VAL_W-1:0] wr_value,
    input  logic             trig,
    output logic [NPROC-1:0] pend_o,
    output logic [NPROC-1:0] run_o
);
    typedef struct packed {
        logic [NPROC-1:0][NSIG-1:0][VAL_W-1:0] vals;
        logic [NPROC-1:0]                      chg;
        logic [NPROC-1:0]                      run;
    } store_t;

    store_t st_d, st_q;
    logic [NPROC-1:0] hit;

    always_comb begin
        st_d = st_q;
        hit  = '0;
        if (wr_en) begin
            if (wr_value != st_q.vals[wr_proc][wr_sig]) begin
                hit[wr_proc] = 1'b1;
            end
            st_d.vals[wr_proc][wr_sig] = wr_value;
        end
        if (trig) begin
            st_d.run = st_q.chg;
            st_d.chg = hit;
        end else begin
            st_d.chg = st_q.chg | hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vals <= '0;
            st_q.chg  <= '1;
            st_q.run  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.chg;
    assign run_o  = st_q.run;

    // R4
    trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !wr_en) |=> (st_q.chg == '0));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !wr_en) |=> $stable(st_q.chg));

    // R4
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> $stable(st_q.run));
endmodule

// File: rtl/pim_activity_counters.sv
module pim_activity_counters #(
    parameter int unsigned NPROC = 32,
    parameter int unsigned CNT_W = 10,
    localparam int unsigned PID_W = $clog2(NPROC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [NPROC-1:0] run_hit,
    input  logic [PID_W-1:0] rd_proc,
    output logic [CNT_W-1:0] rd_trig,
    output logic [CNT_W-1:0] rd_run
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [NPROC-1:0][CNT_W-1:0] trg;
        logic [NPROC-1:0][CNT_W-1:0] run;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (trig) begin
            for (int p = 0; p < NPROC; p++) begin
                if (c_q.trg[p] != CNT_MAX) begin
                    c_d.trg[p] = c_q.trg[p] + 1'b1;
                end
                if (run_hit[p] && (c_q.run[p] != CNT_MAX)) begin
                    c_d.run[p] = c_q.run[p] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_trig = c_q.trg[rd_proc];
    assign rd_run  = c_q.run[rd_proc];

    for (genvar g = 0; g < NPROC; g++) begin : g_chk
        // R7
        no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (c_q.trg[g] >= $past(c_q.trg[g])) && (c_q.run[g] >= $past(c_q.run[g])));
        // R6
        run_le_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
            c_q.run[g] <= c_q.trg[g]);
    end
endmodule

// File: rtl/pim_ratio_cmp.sv
module pim_ratio_cmp #(
    parameter int unsigned CNT_W = 10,
    parameter int unsigned PCT_W = 7,
    parameter int unsigned SCALE = 100,
    localparam int unsigned PRD_W = CNT_W + (PCT_W > 7 ? PCT_W : 7)
) (
    input  logic [CNT_W-1:0] runs,
    input  logic [CNT_W-1:0] trigs,
    input  logic [PCT_W-1:0] pct,
    output logic             active
);
    logic [PRD_W-1:0] lhs, rhs;

    always_comb begin
        lhs    = PRD_W'(runs) * PRD_W'(SCALE);
        rhs    = PRD_W'(trigs) * PRD_W'(pct);
        active = lhs > rhs;
    end
endmodule

// File: rtl/pim_monitor.sv
module pim_monitor
    import pim_pkg::*;
#(
    parameter int unsigned P_NPROC = NPROC,
    parameter int unsigned P_NSIG  = NSIG,
    parameter int unsigned P_VAL_W = VAL_W,
    parameter int unsigned P_CNT_W = CNT_W,
    parameter int unsigned P_PCT_W = PCT_W,
    localparam int unsigned PID_W  = $clog2(P_NPROC),
    localparam int unsigned SID_W  = (P_NSIG > 1) ? $clog2(P_NSIG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PID_W-1:0]   wr_proc,
    input  logic [SID_W-1:0]   wr_sig,
    input  logic [P_VAL_W-1:0] wr_value,
    input  logic               trig,
    output logic [P_NPROC-1:0] run_vec,
    input  logic [P_PCT_W-1:0] thresh_pct,
    input  logic [PID_W-1:0]   rd_proc,
    output logic [P_CNT_W-1:0] rd_trig_cnt,
    output logic [P_CNT_W-1:0] rd_run_cnt,
    output logic               rd_active
);
    typedef struct packed {
        logic [P_CNT_W-1:0] trg;
        logic [P_CNT_W-1:0] run;
        logic               act;
    } rd_t;

    logic [P_NPROC-1:0] pend;
    logic [P_CNT_W-1:0] sel_trig, sel_run;
    logic               sel_act;
    rd_t                rd_d, rd_q;

    pim_value_store #(
        .NPROC(P_NPROC), .NSIG(P_NSIG), .VAL_W(P_VAL_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_proc(wr_proc), .wr_sig(wr_sig), .wr_value(wr_value),
        .trig(trig), .pend_o(pend), .run_o(run_vec)
    );

    pim_activity_counters #(
        .NPROC(P_NPROC), .CNT_W(P_CNT_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .trig(trig), .run_hit(pend),
        .rd_proc(rd_proc), .rd_trig(sel_trig), .rd_run(sel_run)
    );

    pim_ratio_cmp #(
        .CNT_W(P_CNT_W), .PCT_W(P_PCT_W), .SCALE(PCT_SCALE)
    ) u_cmp (
        .runs(sel_run), .trigs(sel_trig), .pct(thresh_pct), .active(sel_act)
    );

    always_comb begin
        rd_d     = rd_q;
        rd_d.trg = sel_trig;
        rd_d.run = sel_run;
        rd_d.act = sel_act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_trig_cnt = rd_q.trg;
    assign rd_run_cnt  = rd_q.run;
    assign rd_active   = rd_q.act;

    // R8
    active_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |-> (rd_run_cnt != '0));

    // R4
    run_only_on_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!trig) |-> $stable(run_vec));
endmodule

// File: tb/pim_monitor_tb.sv
module pim_monitor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_proc = '0;
    logic [1:0]  wr_sig = '0;
    logic [15:0] wr_value = '0;
    logic        trig = 1'b0;
    logic [31:0] run_vec;
    logic [6:0]  thresh_pct = '0;
    logic [4:0]  rd_proc = '0;
    logic [9:0]  rd_trig_cnt, rd_run_cnt;
    logic        rd_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pim_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_proc(wr_proc),
        .wr_sig(wr_sig), .wr_value(wr_value), .trig(trig), .run_vec(run_vec),
        .thresh_pct(thresh_pct), .rd_proc(rd_proc), .rd_trig_cnt(rd_trig_cnt),
        .rd_run_cnt(rd_run_cnt), .rd_active(rd_active)
    );

    // {proc, sig, value, expected run bit}
    localparam logic [23:0] VEC [8] = '{
        {5'd3,  2'd0, 16'h1234, 1'b1},
        {5'd3,  2'd0, 16'h1234, 1'b0},
        {5'd3,  2'd1, 16'h0000, 1'b0},
        {5'd31, 2'd3, 16'hFFFF, 1'b1},
        {5'd0,  2'd2, 16'h0001, 1'b1},
        {5'd0,  2'd2, 16'h0001, 1'b0},
        {5'd31, 2'd3, 16'hFFFE, 1'b1},
        {5'd17, 2'd1, 16'h8000, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] p, input logic [1:0] s, input logic [15:0] v);
        wr_en = 1'b1; wr_proc = p; wr_sig = s; wr_value = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_trig();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic read_proc(input logic [4:0] p, input logic [6:0] pct);
        rd_proc = p; thresh_pct = pct;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 run_vec", run_vec, 32'h0);
        read_proc(5'd4, 7'd0);
        check("R1 trig cnt", 32'(rd_trig_cnt), 32'd0);
        check("R1 run cnt", 32'(rd_run_cnt), 32'd0);
        check("R1 active zero triggers (R8)", 32'(rd_active), 32'd0);
        do_trig();
        check("R1 first trigger all run", run_vec, 32'hFFFF_FFFF);

        // R2 R3 R4 R10 table
        for (int i = 0; i < 8; i++) begin
            logic [31:0] exp;
            do_write(VEC[i][23:19], VEC[i][18:17], VEC[i][16:1]);
            do_trig();
            exp = VEC[i][0] ? (32'h1 << VEC[i][23:19]) : 32'h0;
            check("R2/R3/R4/R10 vector", run_vec, exp);
        end

        // R6 counts: p3 triggered 9 times, ran 2 times
        read_proc(5'd3, 7'd22);
        check("R6 trig count p3", 32'(rd_trig_cnt), 32'd9);
        check("R6 run count p3", 32'(rd_run_cnt), 32'd2);
        check("R8 p3 active at 22", 32'(rd_active), 32'd1);
        read_proc(5'd3, 7'd23);
        check("R8 p3 inactive at 23", 32'(rd_active), 32'd0);
        read_proc(5'd5, 7'd11);
        check("R8 p5 active at 11", 32'(rd_active), 32'd1);
        read_proc(5'd5, 7'd12);
        check("R8 p5 inactive at 12", 32'(rd_active), 32'd0);

        // R9 read latency: change rd_proc, sample before the next edge
        rd_proc = 5'd31;
        #1;
        check("R9 old value held", 32'(rd_run_cnt), 32'd1);
        @(negedge clk);
        check("R9 new value after one edge", 32'(rd_run_cnt), 32'd3);

        // R5 write coinciding with trigger
        wr_en = 1'b1; wr_proc = 5'd7; wr_sig = 2'd1; wr_value = 16'h00A5;
        trig = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; trig = 1'b0;
        check("R5 same-cycle write not counted", run_vec, 32'h0);
        do_trig();
        check("R5 counted at next trigger", run_vec, 32'h0000_0080);

        // R7 saturation
        trig = 1'b1;
        repeat (1100) @(negedge clk);
        trig = 1'b0;
        read_proc(5'd0, 7'd0);
        check("R7 trig count saturates", 32'(rd_trig_cnt), 32'd1023);
        do_trig();
        read_proc(5'd0, 7'd0);
        check("R7 no wrap", 32'(rd_trig_cnt), 32'd1023);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule